// File: doc/BRIEF.md
# Elastic Skip-Compensating Receive FIFO

This block moves 10-bit line symbols from a recovered receive clock into a local read clock that runs at almost, but not exactly, the same rate. It writes one symbol on every write-clock edge and offers one symbol on every read-clock edge. Neither side can be stalled. The two pointers cross between the domains in Gray code through two-flop synchronizers, and the storage is a small register array.

The fill level has to stay inside a band. When the writer's view of the level is above a high-water mark, an incoming skip symbol is discarded instead of stored. When the reader's view of the level is below a low-water mark and the symbol just presented is a skip symbol, the read pointer holds for one cycle, so that skip symbol is presented twice. Two skip code values are programmable: a primary one that is always active and an alternate one with its own enable.

In the read domain, the level is also compared with an upper and a lower threshold. Each comparison sets a sticky status flag. A read-domain clear input resets both flags. Free-running counters record how many skip symbols were removed (write domain) and how many were inserted (read domain).

Top module: `efifo_skip_comp`

## Requirements
- R1: While reset is held, `rd_sym_vld`, `flag_ovf` and `flag_unf` are 0, and both `del_cnt` and `ins_cnt` are 0.
- R2: Every written symbol that does not equal an enabled skip value appears at `rd_sym` exactly once, in write order. Nothing else is added, dropped or repeated.
- R3: A written symbol equal to an enabled skip value is discarded, and `del_cnt` increments by one, only when the write-domain level (written minus synchronized read count) exceeds `cfg_hi_mark`. While that level stays at or below the mark, `del_cnt` does not move.
- R4: When `rd_sym_vld` is 1, `rd_sym` equals an enabled skip value, the read-domain level is below `cfg_lo_mark`, and the previous cycle was not an insertion, the next cycle repeats the same symbol with `rd_sym_vld` = 1, and `ins_cnt` increments by one. Two insertions are never back to back. While the level stays at or above the mark, `ins_cnt` does not move.
- R5: The alternate value `cfg_skip_b` counts as a skip value only while `cfg_skip_b_en` = 1. Otherwise it passes through as ordinary data. `cfg_skip_a` always counts as a skip value.
- R6: `flag_ovf` becomes 1 one read cycle after the read-domain level (synchronized written count minus read count) exceeds `cfg_full_thr`. It then stays 1 until cleared.
- R7: `flag_unf` becomes 1 one read cycle after the read-domain level is below `cfg_empty_thr`. It then stays 1 until cleared.
- R8: A cycle with `flag_clr` = 1 forces both flags to 0 on the next read edge. A flag whose condition no longer holds then stays 0.
- R9: When the read-domain level is 0 and no insertion is due, the next read cycle has `rd_sym_vld` = 0 and the read pointer does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Recovered receive clock (write domain) |
| wr_rst_n | input | 1 | Active-low synchronous reset, write domain |
| wr_sym | input | 10 | Symbol written on every `wr_clk` edge |
| rd_clk | input | 1 | Local read clock |
| rd_rst_n | input | 1 | Active-low synchronous reset, read domain |
| flag_clr | input | 1 | Clears both sticky flags (read domain) |
| cfg_skip_a | input | 10 | Primary skip value, always active |
| cfg_skip_b | input | 10 | Alternate skip value |
| cfg_skip_b_en | input | 1 | Enables the alternate skip value |
| cfg_hi_mark | input | ADDR_W+1 | Write-domain level above which skips are removed |
| cfg_lo_mark | input | ADDR_W+1 | Read-domain level below which skips are repeated |
| cfg_full_thr | input | ADDR_W+1 | Read-domain level above which `flag_ovf` sets |
| cfg_empty_thr | input | ADDR_W+1 | Read-domain level below which `flag_unf` sets |
| rd_sym | output | 10 | Symbol presented to the read side |
| rd_sym_vld | output | 1 | `rd_sym` holds a symbol this cycle |
| flag_ovf | output | 1 | Sticky level-above-threshold flag |
| flag_unf | output | 1 | Sticky level-below-threshold flag |
| del_cnt | output | CNT_W | Skip symbols removed (write domain) |
| ins_cnt | output | CNT_W | Skip symbols inserted (read domain) |

## Verification
A behavioural model in the bench keeps a queue of the non-skip symbols written and checks every valid output symbol against it. A design that dropped data while removing skips, or repeated data instead of a skip, shows up as a mismatch on that cycle. The alternate skip value is first sent as data with its enable off and later used as the skip value with the enable on. A design that ignores the enable would delete or repeat symbols that should have passed through unchanged, and the queue comparison would catch it.

The bench runs the writer first faster and then slower than the reader. In each direction it checks that only the matching counter moves, which catches a design that has the water-mark comparisons inverted. The threshold tests move each threshold across the current level and back. They confirm the flag stays set after its condition has gone and falls only on a clear, so a non-sticky or uncleared flag fails.

// File: rtl/efifo_pkg.sv
// Package: shared symbol type, skip configuration bundle and skip-match helper.
// Assumes the line symbols are 10 bits wide (8b/10b coded stream).
package efifo_pkg;
    localparam int SYM_W = 10;

    typedef logic [SYM_W-1:0] sym_t;

    typedef struct packed {
        sym_t skip_a;
        sym_t skip_b;
        logic skip_b_en;
    } skip_cfg_t;

    // True when the symbol equals an enabled skip value.
    function automatic logic sym_is_skip(input sym_t s, input skip_cfg_t c);
        return (s == c.skip_a) || (c.skip_b_en && (s == c.skip_b));
    endfunction
endpackage

// File: rtl/efifo_ptr_sync.sv
// Module: efifo_ptr_sync
// Carries a Gray-coded pointer into another clock domain through two flops,
// then converts it back to binary.
// Assumes the source changes at most one bit per source clock edge.
module efifo_ptr_sync #(
    parameter int PTR_W = 5
) (
    input  logic             dst_clk,
    input  logic             dst_rst_n,
    input  logic [PTR_W-1:0] src_gray,
    output logic [PTR_W-1:0] dst_bin
);
    logic [PTR_W-1:0] meta_q;
    logic [PTR_W-1:0] sync_q;

    // Two-stage synchronizer into the destination domain.
    always_ff @(posedge dst_clk) begin
        if (!dst_rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= src_gray;
            sync_q <= meta_q;
        end
    end

    // Gray-to-binary: each bit is the XOR of itself and all bits above it.
    for (genvar i = 0; i < PTR_W; i++) begin : g_g2b
        assign dst_bin[i] = ^sync_q[PTR_W-1:i];
    end
endmodule

// File: rtl/efifo_wr_side.sv
// Module: efifo_wr_side
// Write-domain control. Stores one symbol per edge. Drops a skip symbol when
// the local level is above the high-water mark, and refuses a write when the
// array is full.
// Assumes rptr_bin is the read pointer already synchronized into this domain.
module efifo_wr_side
    import efifo_pkg::*;
#(
    parameter  int ADDR_W = 4,
    parameter  int CNT_W  = 16,
    localparam int PTR_W  = ADDR_W + 1,
    localparam int DEPTH  = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  sym_t              wr_sym,
    input  skip_cfg_t         skip_cfg,
    input  logic [PTR_W-1:0]  hi_mark,
    input  logic [PTR_W-1:0]  rptr_bin,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output sym_t              mem_data,
    output logic [PTR_W-1:0]  wptr_gray,
    output logic [PTR_W-1:0]  level,
    output logic [CNT_W-1:0]  del_cnt
);
    logic [PTR_W-1:0] wptr_q;
    logic [PTR_W-1:0] wptr_nx;
    logic             drop;
    logic             full;

    // Level as seen by the writer, and the write/drop decision.
    always_comb begin
        level    = wptr_q - rptr_bin;
        full     = (level == PTR_W'(DEPTH));
        drop     = sym_is_skip(wr_sym, skip_cfg) && (level > hi_mark);
        mem_we   = !drop && !full;
        mem_addr = wptr_q[ADDR_W-1:0];
        mem_data = wr_sym;
        wptr_nx  = mem_we ? wptr_q + PTR_W'(1) : wptr_q;
    end

    // Pointer, its Gray copy for crossing, and the removal counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr_q    <= '0;
            wptr_gray <= '0;
            del_cnt   <= '0;
        end else begin
            wptr_q    <= wptr_nx;
            wptr_gray <= wptr_nx ^ (wptr_nx >> 1);
            if (drop) begin
                del_cnt <= del_cnt + CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/efifo_rd_side.sv
// Module: efifo_rd_side
// Read-domain control. Presents one symbol per edge. Repeats a skip symbol
// when the level is below the low-water mark, and keeps the sticky level flags.
// Assumes wptr_bin is the write pointer already synchronized into this domain.
module efifo_rd_side
    import efifo_pkg::*;
#(
    parameter  int ADDR_W = 4,
    parameter  int CNT_W  = 16,
    localparam int PTR_W  = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  sym_t              mem_rdata,
    input  skip_cfg_t         skip_cfg,
    input  logic [PTR_W-1:0]  lo_mark,
    input  logic [PTR_W-1:0]  full_thr,
    input  logic [PTR_W-1:0]  empty_thr,
    input  logic              flag_clr,
    input  logic [PTR_W-1:0]  wptr_bin,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [PTR_W-1:0]  rptr_gray,
    output logic [PTR_W-1:0]  level,
    output sym_t              rd_sym,
    output logic              rd_vld,
    output logic [CNT_W-1:0]  ins_cnt,
    output logic              flag_ovf,
    output logic              flag_unf
);
    logic [PTR_W-1:0] rptr_q;
    logic [PTR_W-1:0] rptr_nx;
    logic             ins_prev;
    logic             insert;
    logic             take;

    // Level as seen by the reader, and the insert/advance decision.
    always_comb begin
        level    = wptr_bin - rptr_q;
        insert   = rd_vld && !ins_prev && sym_is_skip(rd_sym, skip_cfg) &&
                   (level < lo_mark);
        take     = !insert && (level != '0);
        mem_addr = rptr_q[ADDR_W-1:0];
        rptr_nx  = take ? rptr_q + PTR_W'(1) : rptr_q;
    end

    // Output symbol, pointer, Gray copy and insertion counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rptr_q    <= '0;
            rptr_gray <= '0;
            rd_sym    <= '0;
            rd_vld    <= 1'b0;
            ins_prev  <= 1'b0;
            ins_cnt   <= '0;
        end else begin
            rptr_q    <= rptr_nx;
            rptr_gray <= rptr_nx ^ (rptr_nx >> 1);
            ins_prev  <= insert;
            if (insert) begin
                rd_vld  <= 1'b1;
                ins_cnt <= ins_cnt + CNT_W'(1);
            end else if (take) begin
                rd_sym <= mem_rdata;
                rd_vld <= 1'b1;
            end else begin
                rd_vld <= 1'b0;
            end
        end
    end

    // Sticky threshold flags; the clear takes priority in its own cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_ovf <= 1'b0;
            flag_unf <= 1'b0;
        end else if (flag_clr) begin
            flag_ovf <= 1'b0;
            flag_unf <= 1'b0;
        end else begin
            flag_ovf <= flag_ovf | (level > full_thr);
            flag_unf <= flag_unf | (level < empty_thr);
        end
    end
endmodule

// File: rtl/efifo_skip_comp.sv
// Module: efifo_skip_comp (top)
// Dual-clock elastic FIFO that holds its fill level in a band by removing or
// repeating skip symbols. Holds the storage array and wires the two domain
// controllers and the two pointer synchronizers together.
// Assumes the configuration inputs are static while traffic flows.
module efifo_skip_comp
    import efifo_pkg::*;
#(
    parameter  int ADDR_W = 4,
    parameter  int CNT_W  = 16,
    localparam int PTR_W  = ADDR_W + 1,
    localparam int DEPTH  = 1 << ADDR_W
) (
    input  logic             wr_clk,
    input  logic             wr_rst_n,
    input  logic [9:0]       wr_sym,
    input  logic             rd_clk,
    input  logic             rd_rst_n,
    input  logic             flag_clr,
    input  logic [9:0]       cfg_skip_a,
    input  logic [9:0]       cfg_skip_b,
    input  logic             cfg_skip_b_en,
    input  logic [PTR_W-1:0] cfg_hi_mark,
    input  logic [PTR_W-1:0] cfg_lo_mark,
    input  logic [PTR_W-1:0] cfg_full_thr,
    input  logic [PTR_W-1:0] cfg_empty_thr,
    output logic [9:0]       rd_sym,
    output logic             rd_sym_vld,
    output logic             flag_ovf,
    output logic             flag_unf,
    output logic [CNT_W-1:0] del_cnt,
    output logic [CNT_W-1:0] ins_cnt
);
    skip_cfg_t         skip_cfg;
    sym_t              mem [DEPTH];
    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic [ADDR_W-1:0] mem_raddr;
    sym_t              mem_wdata;
    logic [PTR_W-1:0]  wptr_gray;
    logic [PTR_W-1:0]  rptr_gray;
    logic [PTR_W-1:0]  wptr_in_rd;
    logic [PTR_W-1:0]  rptr_in_wr;
    logic [PTR_W-1:0]  wr_level;
    logic [PTR_W-1:0]  rd_level;

    assign skip_cfg = '{skip_a: cfg_skip_a, skip_b: cfg_skip_b, skip_b_en: cfg_skip_b_en};

    // Storage array, written in the recovered clock domain.
    always_ff @(posedge wr_clk) begin
        if (mem_we) begin
            mem[mem_waddr] <= mem_wdata;
        end
    end

    efifo_wr_side #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_wr (
        .clk       (wr_clk),
        .rst_n     (wr_rst_n),
        .wr_sym    (wr_sym),
        .skip_cfg  (skip_cfg),
        .hi_mark   (cfg_hi_mark),
        .rptr_bin  (rptr_in_wr),
        .mem_we    (mem_we),
        .mem_addr  (mem_waddr),
        .mem_data  (mem_wdata),
        .wptr_gray (wptr_gray),
        .level     (wr_level),
        .del_cnt   (del_cnt)
    );

    efifo_ptr_sync #(.PTR_W(PTR_W)) u_w2r (
        .dst_clk   (rd_clk),
        .dst_rst_n (rd_rst_n),
        .src_gray  (wptr_gray),
        .dst_bin   (wptr_in_rd)
    );

    efifo_ptr_sync #(.PTR_W(PTR_W)) u_r2w (
        .dst_clk   (wr_clk),
        .dst_rst_n (wr_rst_n),
        .src_gray  (rptr_gray),
        .dst_bin   (rptr_in_wr)
    );

    efifo_rd_side #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_rd (
        .clk       (rd_clk),
        .rst_n     (rd_rst_n),
        .mem_rdata (mem[mem_raddr]),
        .skip_cfg  (skip_cfg),
        .lo_mark   (cfg_lo_mark),
        .full_thr  (cfg_full_thr),
        .empty_thr (cfg_empty_thr),
        .flag_clr  (flag_clr),
        .wptr_bin  (wptr_in_rd),
        .mem_addr  (mem_raddr),
        .rptr_gray (rptr_gray),
        .level     (rd_level),
        .rd_sym    (rd_sym),
        .rd_vld    (rd_sym_vld),
        .ins_cnt   (ins_cnt),
        .flag_ovf  (flag_ovf),
        .flag_unf  (flag_unf)
    );
endmodule

// File: rtl/efifo_skip_comp_chk.sv
// Module: efifo_skip_comp_chk
// Property checker for efifo_skip_comp, attached by the bind at the end of
// this file. It watches the ports, both pointer Gray codes and both level
// views.
module efifo_skip_comp_chk #(
    parameter  int ADDR_W = 4,
    parameter  int CNT_W  = 16,
    localparam int PTR_W  = ADDR_W + 1
) (
    input logic             wr_clk,
    input logic             wr_rst_n,
    input logic             rd_clk,
    input logic             rd_rst_n,
    input logic             flag_clr,
    input logic [9:0]       cfg_skip_a,
    input logic [9:0]       cfg_skip_b,
    input logic             cfg_skip_b_en,
    input logic [PTR_W-1:0] cfg_hi_mark,
    input logic [PTR_W-1:0] cfg_lo_mark,
    input logic [9:0]       rd_sym,
    input logic             rd_sym_vld,
    input logic             flag_ovf,
    input logic             flag_unf,
    input logic [CNT_W-1:0] del_cnt,
    input logic [CNT_W-1:0] ins_cnt,
    input logic [PTR_W-1:0] wptr_gray,
    input logic [PTR_W-1:0] rptr_gray,
    input logic [PTR_W-1:0] wr_level,
    input logic [PTR_W-1:0] rd_level
);
    logic out_is_skip;
    assign out_is_skip = (rd_sym == cfg_skip_a) || (cfg_skip_b_en && rd_sym == cfg_skip_b);

    // R2: each pointer moves by at most one Gray bit per edge.
    a_r2_wgray_step: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        $countones(wptr_gray ^ $past(wptr_gray)) <= 1);
    a_r2_rgray_step: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        $countones(rptr_gray ^ $past(rptr_gray)) <= 1);

    // R3: a removal happens only above the high-water mark, one at a time.
    a_r3_del_above_hi: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        (del_cnt != $past(del_cnt)) |-> ($past(wr_level) > $past(cfg_hi_mark)));
    a_r3_del_step: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        (del_cnt != $past(del_cnt)) |-> (del_cnt == $past(del_cnt) + CNT_W'(1)));

    // R4: an insertion repeats a presented skip symbol below the low mark.
    a_r4_ins_repeat: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (ins_cnt != $past(ins_cnt)) |->
            (rd_sym_vld && $past(rd_sym_vld) && $past(out_is_skip) &&
             rd_sym == $past(rd_sym) && $past(rd_level) < $past(cfg_lo_mark)));
    a_r4_no_double: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (ins_cnt != $past(ins_cnt)) |=> $stable(ins_cnt));

    // R6, R7: the flags are sticky while no clear is requested.
    a_r6_ovf_sticky: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (flag_ovf && !flag_clr) |=> flag_ovf);
    a_r7_unf_sticky: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (flag_unf && !flag_clr) |=> flag_unf);

    // R8: a clear drops both flags on the next edge.
    a_r8_clear: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        flag_clr |=> (!flag_ovf && !flag_unf));

    // R9: an empty read view without an insertion yields no valid symbol.
    a_r9_empty: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        ($past(rd_level) == '0 && $stable(ins_cnt)) |-> !rd_sym_vld);
endmodule

bind efifo_skip_comp efifo_skip_comp_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .wr_clk        (wr_clk),
    .wr_rst_n      (wr_rst_n),
    .rd_clk        (rd_clk),
    .rd_rst_n      (rd_rst_n),
    .flag_clr      (flag_clr),
    .cfg_skip_a    (cfg_skip_a),
    .cfg_skip_b    (cfg_skip_b),
    .cfg_skip_b_en (cfg_skip_b_en),
    .cfg_hi_mark   (cfg_hi_mark),
    .cfg_lo_mark   (cfg_lo_mark),
    .rd_sym        (rd_sym),
    .rd_sym_vld    (rd_sym_vld),
    .flag_ovf      (flag_ovf),
    .flag_unf      (flag_unf),
    .del_cnt       (del_cnt),
    .ins_cnt       (ins_cnt),
    .wptr_gray     (wptr_gray),
    .rptr_gray     (rptr_gray),
    .wr_level      (wr_level),
    .rd_level      (rd_level)
);

// File: tb/test_efifo_skip_comp.sv
// Bench for efifo_skip_comp. A behavioural queue model holds every non-skip
// symbol written and is compared with each valid output symbol on every read
// clock. Phase checks cover the counters and the flags.
`timescale 1ps/1ps
module test_efifo_skip_comp;
    localparam int ADDR_W = 4;
    localparam int CNT_W  = 16;
    localparam int PTR_W  = ADDR_W + 1;
    localparam logic [9:0] SKA = 10'h17C;
    localparam logic [9:0] SKB = 10'h283;

    logic             wr_clk = 1'b0, rd_clk = 1'b0;
    logic             wr_rst_n = 1'b0, rd_rst_n = 1'b0;
    logic [9:0]       wr_sym = SKA;
    logic             flag_clr = 1'b0;
    logic [9:0]       cfg_skip_a = SKA, cfg_skip_b = SKB;
    logic             cfg_skip_b_en = 1'b0;
    logic [PTR_W-1:0] cfg_hi_mark = 5'd10, cfg_lo_mark = 5'd5;
    logic [PTR_W-1:0] cfg_full_thr = 5'd14, cfg_empty_thr = 5'd2;
    logic [9:0]       rd_sym;
    logic             rd_sym_vld, flag_ovf, flag_unf;
    logic [CNT_W-1:0] del_cnt, ins_cnt;

    int wr_half = 1900;
    int rd_half = 2000;              // 250 MHz read clock
    int checks = 0, failures = 0, data_seen = 0;
    int wr_mode = 0;
    bit wr_go = 1'b0;
    int k = 0;
    logic [9:0] exp_q[$];

    efifo_skip_comp #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_efifo_skip_comp (.*);

    initial forever #(wr_half) wr_clk = ~wr_clk;
    initial forever #(rd_half) rd_clk = ~rd_clk;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic wait_rd(input int n);
        repeat (n) @(negedge rd_clk);
    endtask

    task automatic pulse_clr();
        @(negedge rd_clk) flag_clr = 1'b1;
        @(negedge rd_clk) flag_clr = 1'b0;
    endtask

    // Writer: modes 0 = data with SKB sent as data, 1 = SKB used as skip,
    // 2 = SKA skip with data, 3 = SKA only.
    always @(negedge wr_clk) begin
        if (wr_go) begin
            logic [9:0] d;
            d = 10'((k * 37 + 5) & 10'h3FF);
            if (d == SKA || d == SKB) d = d ^ 10'h001;
            if (wr_mode == 3 || (k % 6) == 5) begin
                wr_sym = (wr_mode == 1) ? SKB : SKA;
            end else if (wr_mode == 0 && (k % 11) == 3) begin
                wr_sym = SKB;
                exp_q.push_back(SKB);
            end else begin
                wr_sym = d;
                exp_q.push_back(d);
            end
            k++;
        end
    end

    // Reference comparison on every read clock (R2, R5).
    always @(negedge rd_clk) begin
        if (rd_rst_n && rd_sym_vld) begin
            if (!(rd_sym == cfg_skip_a || (cfg_skip_b_en && rd_sym == cfg_skip_b))) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2", "unexpected data symbol", int'(rd_sym), -1);
                end else begin
                    logic [9:0] e;
                    e = exp_q.pop_front();
                    data_seen++;
                    check(rd_sym == e, (e == SKB) ? "R5" : "R2", "data order",
                          int'(rd_sym), int'(e));
                end
            end
        end
    end

    initial begin
        repeat (2000000) @(posedge rd_clk);
        check(1'b0, "R2", "watchdog expired", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int d0, i0;
        wait_rd(10);
        // R1: reset state
        check(rd_sym_vld == 1'b0, "R1", "vld in reset", int'(rd_sym_vld), 0);
        check(flag_ovf == 1'b0 && flag_unf == 1'b0, "R1", "flags in reset",
              int'({flag_ovf, flag_unf}), 0);
        check(del_cnt == '0 && ins_cnt == '0, "R1", "counters in reset",
              int'(del_cnt) + int'(ins_cnt), 0);
        @(negedge wr_clk) wr_rst_n = 1'b1;
        wr_go = 1'b1;
        @(negedge rd_clk) rd_rst_n = 1'b1;
        @(negedge rd_clk);
        // R9: synchronized write pointer not yet visible, so nothing valid
        check(rd_sym_vld == 1'b0, "R9", "vld while empty", int'(rd_sym_vld), 0);

        // Writer faster: level rises to the high mark, skips get removed
        wait_rd(500);
        i0 = int'(ins_cnt);
        wait_rd(1000);
        check(del_cnt != '0, "R3", "removals with fast writer", int'(del_cnt), 1);
        check(int'(ins_cnt) == i0, "R4", "no insertion above low mark", int'(ins_cnt), i0);
        check(flag_unf == 1'b1, "R7", "underflow set at start", int'(flag_unf), 1);
        pulse_clr();
        wait_rd(5);
        check(flag_unf == 1'b0, "R8", "underflow cleared", int'(flag_unf), 0);
        check(flag_ovf == 1'b0, "R6", "no overflow below threshold", int'(flag_ovf), 0);

        // Overflow threshold crossed, then restored
        cfg_full_thr = 5'd3;
        wait_rd(20);
        check(flag_ovf == 1'b1, "R6", "overflow set", int'(flag_ovf), 1);
        cfg_full_thr = 5'd14;
        wait_rd(10);
        check(flag_ovf == 1'b1, "R6", "overflow sticky", int'(flag_ovf), 1);
        pulse_clr();
        wait_rd(10);
        check(flag_ovf == 1'b0, "R8", "overflow cleared", int'(flag_ovf), 0);

        // Alternate skip enabled and used as the skip value
        wr_mode = 3;
        wait_rd(60);
        cfg_skip_b_en = 1'b1;
        wr_mode = 1;
        wait_rd(20);
        d0 = int'(del_cnt);
        wait_rd(800);
        check(int'(del_cnt) > d0, "R5", "alternate skip removed", int'(del_cnt), d0 + 1);

        // Reader faster: level falls to the low mark, skips get repeated
        wr_mode = 2;
        wait_rd(60);
        cfg_skip_b_en = 1'b0;
        wr_half = 2100;
        wait_rd(600);
        d0 = int'(del_cnt);
        i0 = int'(ins_cnt);
        pulse_clr();
        wait_rd(1500);
        check(int'(ins_cnt) > i0, "R4", "insertions with slow writer", int'(ins_cnt), i0 + 1);
        check(int'(del_cnt) == d0, "R3", "no removal below high mark", int'(del_cnt), d0);
        check(flag_unf == 1'b0, "R7", "no underflow above threshold", int'(flag_unf), 0);

        // Underflow threshold crossed, then restored
        cfg_empty_thr = 5'd12;
        wait_rd(20);
        check(flag_unf == 1'b1, "R7", "underflow set", int'(flag_unf), 1);
        cfg_empty_thr = 5'd2;
        wait_rd(10);
        check(flag_unf == 1'b1, "R7", "underflow sticky", int'(flag_unf), 1);
        pulse_clr();
        wait_rd(10);
        check(flag_unf == 1'b0, "R8", "underflow cleared", int'(flag_unf), 0);

        // Drain with skip-only traffic: every data symbol delivered
        wr_mode = 3;
        wait_rd(300);
        check(exp_q.size() == 0, "R2", "queue drained", exp_q.size(), 0);
        check(data_seen > 1000, "R2", "data symbols delivered", data_seen, 1001);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule